// File: doc/BRIEF.md
# Asynchronous Memory Phase Sequencer

This block runs single read and write accesses on an asynchronous parallel memory port (static RAM, NOR or NAND style devices) with four chip selects. Each chip select has its own timing set: setup, strobe and hold widths for reads and for writes, a minimum gap used when the bus changes hands, a data width of 8 or 16 bits, a mode in which the select line is asserted only while the strobe is active, and an option to let a device wait line lengthen the strobe.

A host presents one request at a time on a valid/ack port. The request carries the chip select, the direction, a 26-bit byte address (a 64 MB window per select, 256 MB over all four) and write data. The request must stay valid until the one-cycle acknowledge, when read data can be taken. Timing values arrive on static configuration inputs, one field per chip select. The fields are packed with chip select 0 in the least significant slice.

Top module: `amem_phase_engine`

## Requirements
- R1: Once accepted, an access runs a setup phase, then a strobe phase, then a hold phase. A read holds `mem_oe_n` low and a write holds `mem_we_n` low only for the strobe phase. `req_ack` is high during the last hold cycle, S+T+H cycles after the accepting edge, where S, T and H are the phase widths.
- R2: A phase width programmed as 0 behaves exactly as a width of 1.
- R3: When the previous access used a different chip select or the other direction, the new access starts only after the previous chip select's turnaround count of extra idle cycles. When both the chip select and the direction repeat, no extra cycle is added.
- R4: With select strobe mode off, the chosen `mem_cs_n` bit is low for setup, strobe and hold. With the mode on, it is low only during the strobe. Unselected bits stay high.
- R5: With extended wait on, a synchronised high on that chip select's `mem_wait` bit holds the strobe phase once its programmed width has run out. The strobe ends two cycles after the wait bit goes low, and is never shorter than its programmed width. With extended wait off, the wait bit has no effect on the strobe width.
- R6: Read data is sampled from `mem_dq_in` on the edge that ends the strobe and is shown on `rsp_rdata`. For an 8-bit chip select, bits 15:8 are zero.
- R7: During a write, `mem_dq_oe` is high from the first setup cycle through the last hold cycle and `mem_dq_out` carries the write data. For an 8-bit chip select, bits 15:8 are driven zero. `mem_dq_oe` is never high during a read.
- R8: For a 16-bit chip select, `mem_addr` is the request address shifted right by one (a halfword address). For an 8-bit chip select, the byte address passes through unchanged.
- R9: After reset, every `mem_cs_n` bit, `mem_oe_n` and `mem_we_n` are high, and `mem_dq_oe` and `req_ack` are low. `req_ack` never stays high for two cycles in a row.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and at most one `mem_cs_n` bit is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_setup | input | 16 | Read setup width, 4 bits per chip select |
| cfg_rd_strobe | input | 16 | Read strobe width, 4 bits per chip select |
| cfg_rd_hold | input | 16 | Read hold width, 4 bits per chip select |
| cfg_wr_setup | input | 16 | Write setup width, 4 bits per chip select |
| cfg_wr_strobe | input | 16 | Write strobe width, 4 bits per chip select |
| cfg_wr_hold | input | 16 | Write hold width, 4 bits per chip select |
| cfg_turn | input | 16 | Turnaround idle cycles, 4 bits per chip select |
| cfg_wide | input | 4 | 1 selects a 16-bit data bus for that chip select, 0 selects 8 bits |
| cfg_sel_strobe | input | 4 | Select strobe mode enable per chip select |
| cfg_ext_wait | input | 4 | Extended wait enable per chip select |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target chip select |
| req_addr | input | 26 | Byte address inside the chip select window |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data of the last read |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 26 | Device address |
| mem_dq_out | output | 16 | Data driven toward the device |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the device |
| mem_wait | input | 4 | Device wait request, one bit per chip select |

## Verification
Every output derives from registered state, so after the accepting clock edge an access shows S setup cycles, T strobe cycles (stretched for wait) and H hold cycles, with `req_ack` in cycle S+T+H. When a turnaround applies, everything shifts later by that count. The bench raises a request at a falling edge and counts falling edges until it sees the acknowledge, sampling each output mid-cycle. It counts, per access, the cycles in which the select, strobe and data enable are active, and records the index of the first strobe cycle, the address, and the write data. A released wait is expected to end the strobe two cycles later, because of the synchroniser. Captured read data is compared against a device model whose output is a fixed function of `mem_addr`.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int unsigned PH_W = 4;
    localparam int unsigned TA_W = 4;

    typedef logic [PH_W-1:0] ph_cnt_t;
    typedef logic [TA_W-1:0] ta_cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        ph_cnt_t setup;
        ph_cnt_t strobe;
        ph_cnt_t hold;
    } ph_widths_t;

    typedef struct packed {
        ph_widths_t rd;
        ph_widths_t wr;
        ta_cnt_t    turn;
        logic       wide;
        logic       sel_strobe;
        logic       ext_wait;
    } cs_cfg_t;

    function automatic ph_cnt_t at_least_one(ph_cnt_t v);
        return (v == '0) ? ph_cnt_t'(1) : v;
    endfunction

endpackage

// File: rtl/amem_wait_sync.sv
module amem_wait_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage1_q;
    logic [N-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/amem_cfg_sel.sv
module amem_cfg_sel
    import amem_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*PH_W-1:0] rd_setup_i,
    input  logic [NUM_CS*PH_W-1:0] rd_strobe_i,
    input  logic [NUM_CS*PH_W-1:0] rd_hold_i,
    input  logic [NUM_CS*PH_W-1:0] wr_setup_i,
    input  logic [NUM_CS*PH_W-1:0] wr_strobe_i,
    input  logic [NUM_CS*PH_W-1:0] wr_hold_i,
    input  logic [NUM_CS*TA_W-1:0] turn_i,
    input  logic [NUM_CS-1:0]      wide_i,
    input  logic [NUM_CS-1:0]      sel_strobe_i,
    input  logic [NUM_CS-1:0]      ext_wait_i,
    input  logic [CS_W-1:0]        sel_i,
    output cs_cfg_t                cfg_o
);
    cs_cfg_t per_cs [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_comb begin
            per_cs[g].rd.setup   = at_least_one(rd_setup_i[g*PH_W +: PH_W]);
            per_cs[g].rd.strobe  = at_least_one(rd_strobe_i[g*PH_W +: PH_W]);
            per_cs[g].rd.hold    = at_least_one(rd_hold_i[g*PH_W +: PH_W]);
            per_cs[g].wr.setup   = at_least_one(wr_setup_i[g*PH_W +: PH_W]);
            per_cs[g].wr.strobe  = at_least_one(wr_strobe_i[g*PH_W +: PH_W]);
            per_cs[g].wr.hold    = at_least_one(wr_hold_i[g*PH_W +: PH_W]);
            per_cs[g].turn       = turn_i[g*TA_W +: TA_W];
            per_cs[g].wide       = wide_i[g];
            per_cs[g].sel_strobe = sel_strobe_i[g];
            per_cs[g].ext_wait   = ext_wait_i[g];
        end
    end

    assign cfg_o = per_cs[sel_i];
endmodule

// File: rtl/amem_phase_engine.sv
module amem_phase_engine
    import amem_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CS*PH_W-1:0] cfg_rd_setup,
    input  logic [NUM_CS*PH_W-1:0] cfg_rd_strobe,
    input  logic [NUM_CS*PH_W-1:0] cfg_rd_hold,
    input  logic [NUM_CS*PH_W-1:0] cfg_wr_setup,
    input  logic [NUM_CS*PH_W-1:0] cfg_wr_strobe,
    input  logic [NUM_CS*PH_W-1:0] cfg_wr_hold,
    input  logic [NUM_CS*TA_W-1:0] cfg_turn,
    input  logic [NUM_CS-1:0]      cfg_wide,
    input  logic [NUM_CS-1:0]      cfg_sel_strobe,
    input  logic [NUM_CS-1:0]      cfg_ext_wait,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [CS_W-1:0]        req_cs,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ack,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [NUM_CS-1:0]      mem_cs_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in,
    input  logic [NUM_CS-1:0]      mem_wait
);
    localparam int unsigned NARROW_W = DATA_W / 2;
    localparam int unsigned PAD_W    = DATA_W - NARROW_W;

    typedef struct packed {
        phase_e              ph;
        ph_cnt_t             cnt;
        logic [CS_W-1:0]     cs;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        cs_cfg_t             cfg;
        logic                prev_valid;
        logic [CS_W-1:0]     last_cs;
        logic                last_wr;
        ta_cnt_t             last_turn;
        ta_cnt_t             gap;
    } eng_state_t;

    eng_state_t      st_d, st_q;
    cs_cfg_t         req_cfg;
    logic [NUM_CS-1:0] wait_s;
    logic            need_turn;
    logic            may_start;
    logic            cs_active;
    logic [NUM_CS-1:0] cs_onehot;

    amem_cfg_sel #(.NUM_CS(NUM_CS)) cfg_sel_i (
        .rd_setup_i   (cfg_rd_setup),
        .rd_strobe_i  (cfg_rd_strobe),
        .rd_hold_i    (cfg_rd_hold),
        .wr_setup_i   (cfg_wr_setup),
        .wr_strobe_i  (cfg_wr_strobe),
        .wr_hold_i    (cfg_wr_hold),
        .turn_i       (cfg_turn),
        .wide_i       (cfg_wide),
        .sel_strobe_i (cfg_sel_strobe),
        .ext_wait_i   (cfg_ext_wait),
        .sel_i        (req_cs),
        .cfg_o        (req_cfg)
    );

    amem_wait_sync #(.N(NUM_CS)) wait_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (mem_wait),
        .sync_o (wait_s)
    );

    // a change of owner or direction needs the previous select's gap
    assign need_turn = st_q.prev_valid &&
                       ((req_cs != st_q.last_cs) || (req_write != st_q.last_wr));
    assign may_start = !need_turn || (st_q.gap >= st_q.last_turn);

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (st_q.gap != '1) begin
                    st_d.gap = st_q.gap + 1'b1;
                end
                if (req_valid && may_start) begin
                    st_d.ph    = PH_SETUP;
                    st_d.cs    = req_cs;
                    st_d.wr    = req_write;
                    st_d.cfg   = req_cfg;
                    st_d.addr  = req_cfg.wide ? {1'b0, req_addr[ADDR_W-1:1]} : req_addr;
                    st_d.wdata = req_cfg.wide ? req_wdata
                                              : {{PAD_W{1'b0}}, req_wdata[NARROW_W-1:0]};
                    st_d.cnt   = (req_write ? req_cfg.wr.setup : req_cfg.rd.setup) - 1'b1;
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = (st_q.wr ? st_q.cfg.wr.strobe : st_q.cfg.rd.strobe) - 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (!(st_q.cfg.ext_wait && wait_s[st_q.cs])) begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = (st_q.wr ? st_q.cfg.wr.hold : st_q.cfg.rd.hold) - 1'b1;
                    if (!st_q.wr) begin
                        st_d.rdata = st_q.cfg.wide
                                   ? mem_dq_in
                                   : {{PAD_W{1'b0}}, mem_dq_in[NARROW_W-1:0]};
                    end
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph         = PH_IDLE;
                    st_d.gap        = '0;
                    st_d.prev_valid = 1'b1;
                    st_d.last_cs    = st_q.cs;
                    st_d.last_wr    = st_q.wr;
                    st_d.last_turn  = st_q.cfg.turn;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_active = st_q.cfg.sel_strobe ? (st_q.ph == PH_STROBE)
                                           : (st_q.ph != PH_IDLE);

    always_comb begin
        cs_onehot = '0;
        if (cs_active) begin
            cs_onehot[st_q.cs] = 1'b1;
        end
    end

    assign mem_cs_n   = ~cs_onehot;
    assign mem_oe_n   = !((st_q.ph == PH_STROBE) && !st_q.wr);
    assign mem_we_n   = !((st_q.ph == PH_STROBE) && st_q.wr);
    assign mem_dq_oe  = (st_q.ph != PH_IDLE) && st_q.wr;
    assign mem_dq_out = st_q.wdata;
    assign mem_addr   = st_q.addr;
    assign req_ack    = (st_q.ph == PH_HOLD) && (st_q.cnt == '0);
    assign rsp_rdata  = st_q.rdata;
endmodule

// File: rtl/amem_phase_checker.sv
module amem_phase_checker #(
    parameter int unsigned NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              ack
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_single_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    assert_setup_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(dq_oe));

    assert_strobe_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> ($countones(~cs_n) == 1));
endmodule

bind amem_phase_engine amem_phase_checker #(.NUM_CS(NUM_CS)) phase_chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (mem_cs_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .dq_oe (mem_dq_oe),
    .ack   (req_ack)
);

// File: tb/amem_phase_engine_tb_top.sv
module amem_phase_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold;
    logic [15:0] cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold, cfg_turn;
    logic [3:0]  cfg_wide, cfg_sel_strobe, cfg_ext_wait;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic [3:0]  mem_wait = '0;

    int n_checks = 0;
    int n_fail   = 0;

    int m_total, m_cs, m_strb, m_dqoe, m_first;
    logic [25:0] m_addr;
    logic [15:0] m_dout, m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    // device model: read data is a fixed function of the address
    assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

    // chip selects listed 3..0: cs0 slow wide, cs1 all zero, cs2 strobe-select + wait, cs3 wide
    assign cfg_rd_setup   = {4'd3, 4'd1, 4'd0, 4'd2};
    assign cfg_rd_strobe  = {4'd2, 4'd2, 4'd0, 4'd3};
    assign cfg_rd_hold    = {4'd2, 4'd1, 4'd0, 4'd1};
    assign cfg_wr_setup   = {4'd1, 4'd2, 4'd0, 4'd1};
    assign cfg_wr_strobe  = {4'd1, 4'd1, 4'd0, 4'd2};
    assign cfg_wr_hold    = {4'd1, 4'd1, 4'd0, 4'd2};
    assign cfg_turn       = {4'd0, 4'd2, 4'd0, 4'd3};
    assign cfg_wide       = 4'b1001;
    assign cfg_sel_strobe = 4'b0100;
    assign cfg_ext_wait   = 4'b0100;

    amem_phase_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_turn(cfg_turn), .cfg_wide(cfg_wide), .cfg_sel_strobe(cfg_sel_strobe),
        .cfg_ext_wait(cfg_ext_wait),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input bit wide, input logic [25:0] a);
        logic [25:0] m;
        logic [15:0] v;
        m = wide ? (a >> 1) : a;
        v = m[15:0] ^ 16'h5A3C;
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic run_access(input int cs, input bit wr, input logic [25:0] addr,
                              input logic [15:0] wd, input int pre_idle, input int wait_release);
        int guard;
        repeat (pre_idle) @(negedge clk);
        @(negedge clk);
        check("R9 ack low between accesses", int'(req_ack), 0);
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs); req_addr = addr; req_wdata = wd;
        m_total = 0; m_cs = 0; m_strb = 0; m_dqoe = 0; m_first = 0;
        m_addr = '0; m_dout = '0; m_rdata = '0;
        guard = 0;
        forever begin
            @(negedge clk);
            m_total++;
            guard++;
            if (!mem_cs_n[cs]) m_cs++;
            if (mem_dq_oe) m_dqoe++;
            if ((wr && !mem_we_n) || (!wr && !mem_oe_n)) begin
                m_strb++;
                if (m_first == 0) m_first = m_total;
                m_addr = mem_addr;
                m_dout = mem_dq_out;
            end
            if (wait_release > 0 && m_strb == wait_release) mem_wait[cs] = 1'b0;
            if (req_ack) begin
                m_rdata = rsp_rdata;
                break;
            end
            if (guard > 200) begin
                check("R1 access completes", 0, 1);
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 reset cs_n", int'(mem_cs_n), 4'hF);
        check("R9 reset oe_n", int'(mem_oe_n), 1);
        check("R9 reset we_n", int'(mem_we_n), 1);
        check("R9 reset dq_oe", int'(mem_dq_oe), 0);
        check("R9 reset ack", int'(req_ack), 0);
    endtask

    task automatic t_read_wide();
        run_access(0, 1'b0, 26'h0012346, 16'h0, 0, 0);
        check("R1 read total cycles", m_total, 6);
        check("R1 read strobe width", m_strb, 3);
        check("R1 read strobe after setup", m_first, 3);
        check("R4 cs low whole cycle", m_cs, 6);
        check("R7 no drive on read", m_dqoe, 0);
        check("R8 halfword address", int'(m_addr), int'(26'h0012346 >> 1));
        check("R6 wide read data", int'(m_rdata), int'(exp_rd(1'b1, 26'h0012346)));
    endtask

    task automatic t_read_same();
        run_access(0, 1'b0, 26'h3FFFFFE, 16'h0, 0, 0);
        check("R3 no turnaround same cs and dir", m_total, 6);
        check("R6 wide read data top", int'(m_rdata), int'(exp_rd(1'b1, 26'h3FFFFFE)));
    endtask

    task automatic t_write_turn();
        run_access(0, 1'b1, 26'h0000100, 16'hBEEF, 0, 0);
        check("R3 turnaround on direction change", m_total, 8);
        check("R3 strobe delayed by turnaround", m_first, 5);
        check("R1 write strobe width", m_strb, 2);
        check("R7 data enable setup to hold", m_dqoe, 5);
        check("R7 write data", int'(m_dout), 16'hBEEF);
    endtask

    task automatic t_clamp_read();
        run_access(1, 1'b0, 26'h00000A7, 16'h0, 0, 0);
        check("R3 turnaround on cs change", m_total, 6);
        check("R2 zero strobe acts as one", m_strb, 1);
        check("R2 zero widths cs span", m_cs, 3);
        check("R8 byte address", int'(m_addr), 'hA7);
        check("R6 narrow read data", int'(m_rdata), int'(exp_rd(1'b0, 26'h00000A7)));
    endtask

    task automatic t_clamp_write();
        run_access(1, 1'b1, 26'h0000055, 16'h1234, 0, 0);
        check("R2 zero widths write total", m_total, 3);
        check("R7 narrow write upper zero", int'(m_dout), 16'h0034);
        check("R7 narrow write enable span", m_dqoe, 3);
    endtask

    task automatic t_wait_stretch();
        mem_wait[2] = 1'b1;
        run_access(2, 1'b0, 26'h0000311, 16'h0, 3, 5);
        check("R5 wait stretches strobe", m_strb, 7);
        check("R5 stretched total", m_total, 9);
        check("R4 select strobe mode cs span", m_cs, 7);
    endtask

    task automatic t_nowait_strobe();
        run_access(2, 1'b0, 26'h0000312, 16'h0, 0, 0);
        check("R5 no wait programmed strobe", m_strb, 2);
        check("R4 select strobe mode cs span", m_cs, 2);
        check("R1 total cycles cs2 read", m_total, 4);
    endtask

    task automatic t_wait_ignored();
        mem_wait[3] = 1'b1;
        run_access(3, 1'b0, 26'h0001000, 16'h0, 0, 0);
        check("R5 wait ignored when disabled", m_strb, 2);
        check("R3 turnaround from cs2", m_total, 9);
        mem_wait[3] = 1'b0;
    endtask

    task automatic t_strobe_write();
        run_access(2, 1'b1, 26'h0000020, 16'hA1C7, 0, 0);
        check("R4 select strobe write cs span", m_cs, 1);
        check("R1 cs2 write total", m_total, 4);
        check("R7 cs2 write enable span", m_dqoe, 4);
        check("R7 cs2 narrow write data", int'(m_dout), 16'h00C7);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_wide();
        t_read_same();
        t_write_turn();
        t_clamp_read();
        t_clamp_write();
        t_wait_stretch();
        t_nowait_strobe();
        t_wait_ignored();
        t_strobe_write();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule